// File: doc/BRIEF.md
# Two-Layer Strip Coincidence Trigger

This block sits behind the discriminators of a two-layer strip tracker and decides, every bunch-crossing cycle, which columns saw a track crossing both layers. The upper layer gives one hit bit per long strip. The lower layer gives five hit bits per column, one for each short strip. For every column the five short-strip bits are merged into one "group hit", and that bit is ANDed with the long-strip bit of the same column. All strip bits and the resulting coincidence flags are registered once per cycle, together with a summary flag that is high when any column fired.

A readout request freezes a snapshot of the registered hit map and coincidence flags into a shift register. The snapshot is then sent out one bit per cycle behind a fixed 8-bit header. The live coincidence outputs keep updating while the frame is being sent.

Top module: `strip_coinc_trigger`

## Requirements
- R1: On each rising clock edge, `coinc[i]` takes the value `up_hit[i] AND (OR of lo_hit[5*i+0] .. lo_hit[5*i+4])` from the inputs present at that edge. The new value is visible one cycle after the inputs are applied.
- R2: Which of the five short strips in column i is hit does not change `coinc[i]`. A single lower hit at index 5*i+s, with all upper strips hit, sets exactly bit i for every s in 0..4.
- R3: `coinc_any` is registered on the same edge as `coinc` and equals the OR of all 64 bits of `coinc` in every cycle.
- R4: A `rd_req` sampled high while `busy` is low captures a snapshot of the registered upper hits, lower hits and coincidence flags as they are shown in that cycle.
- R5: Frame bit k, sent in the k-th busy cycle, is as follows. For k in 0..7 it is bit k of 0xA5 (LSB first: 1,0,1,0,0,1,0,1). For k = 8+i it is upper strip i. For k = 72+5*g+s it is lower strip s of group g. For k = 392+i it is coincidence bit i.
- R6: `busy` and `ser_valid` rise in the cycle after an accepted request and stay high for exactly 456 cycles. `ser_data` is 0 whenever `ser_valid` is low.
- R7: A `rd_req` sampled while `busy` is high is ignored. This holds in the last busy cycle as well. The frame in progress is neither restarted nor altered.
- R8: While a frame is being sent, `coinc` and `coinc_any` keep following the inputs as in R1 and R3, and input changes do not alter the frame contents.
- R9: While `rst_n` is low and right after it is released, `coinc`, `coinc_any`, `busy`, `ser_valid` and `ser_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_hit | input | 64 | Upper-layer long-strip hits, one per column |
| lo_hit | input | 320 | Lower-layer short-strip hits; bit 5*g+s is strip s of column g |
| rd_req | input | 1 | Request to snapshot and send a frame |
| coinc | output | 64 | Registered per-column coincidence flags |
| coinc_any | output | 1 | Registered OR of all coincidence flags |
| ser_valid | output | 1 | High while a frame bit is on `ser_data` |
| ser_data | output | 1 | Serial frame bit |
| busy | output | 1 | Frame transmission in progress |

## Verification
The hardest situation to reach is a frame that stays intact while everything around it moves. To create it, the bench changes the strip inputs every cycle during transmission, issues a new request in the middle of a frame, and issues another in the very last busy cycle. It then compares all 456 received bits with a frame it builds from the captured pattern. The bench also sweeps every short-strip position of every column one at a time, which covers the position independence of the group merge.

// File: rtl/strip_coinc_pkg.sv
package strip_coinc_pkg;
  localparam int HDR_W = 8;
  localparam logic [HDR_W-1:0] HDR_WORD = 8'hA5;

  function automatic int frame_bits(input int n_col, input int n_sub);
    return HDR_W + 2 * n_col + n_col * n_sub;
  endfunction
endpackage

// File: rtl/coinc_array.sv
module coinc_array #(
  parameter int N_COL = 64,
  parameter int N_SUB = 5
) (
  input  logic [N_COL-1:0]       up_hit,
  input  logic [N_COL*N_SUB-1:0] lo_hit,
  output logic [N_COL-1:0]       coinc_nxt,
  output logic                   any_nxt
);
  logic [N_COL-1:0] grp_hit;

  for (genvar c = 0; c < N_COL; c++) begin : g_col
    assign grp_hit[c]   = |lo_hit[c*N_SUB +: N_SUB];
    assign coinc_nxt[c] = up_hit[c] & grp_hit[c];
  end

  assign any_nxt = |coinc_nxt;
endmodule

// File: rtl/hit_latch.sv
module hit_latch #(
  parameter int N_COL = 64,
  parameter int N_SUB = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_COL-1:0]       up_d,
  input  logic [N_COL*N_SUB-1:0] lo_d,
  input  logic [N_COL-1:0]       coinc_d,
  input  logic                   any_d,
  output logic [N_COL-1:0]       up_q,
  output logic [N_COL*N_SUB-1:0] lo_q,
  output logic [N_COL-1:0]       coinc_q,
  output logic                   any_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q    <= '0;
      lo_q    <= '0;
      coinc_q <= '0;
      any_q   <= 1'b0;
    end else begin
      up_q    <= up_d;
      lo_q    <= lo_d;
      coinc_q <= coinc_d;
      any_q   <= any_d;
    end
  end
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
  parameter int FRAME_W = 456
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame,
  input  logic               req,
  output logic               load_evt,
  output logic               busy,
  output logic               ser_data
);
  localparam int CW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CW-1:0]      left;

  assign busy     = (left != '0);
  assign load_evt = req & ~busy;
  assign ser_data = shreg[0] & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load_evt) begin
      shreg <= frame;
      left  <= CW'(FRAME_W);
    end else if (busy) begin
      shreg <= shreg >> 1;
      left  <= left - 1'b1;
    end
  end
endmodule

// File: rtl/strip_coinc_trigger.sv
module strip_coinc_trigger #(
  parameter int N_COL = 64,
  parameter int N_SUB = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_COL-1:0]       up_hit,
  input  logic [N_COL*N_SUB-1:0] lo_hit,
  input  logic                   rd_req,
  output logic [N_COL-1:0]       coinc,
  output logic                   coinc_any,
  output logic                   ser_valid,
  output logic                   ser_data,
  output logic                   busy
);
  import strip_coinc_pkg::*;

  localparam int N_LO    = N_COL * N_SUB;
  localparam int FRAME_W = frame_bits(N_COL, N_SUB);

  logic [N_COL-1:0]   coinc_nxt;
  logic               any_nxt;
  logic [N_COL-1:0]   up_q;
  logic [N_LO-1:0]    lo_q;
  logic [FRAME_W-1:0] frame;
  logic               load_evt;

  coinc_array #(.N_COL(N_COL), .N_SUB(N_SUB)) u_arr (
    .up_hit(up_hit), .lo_hit(lo_hit), .coinc_nxt(coinc_nxt), .any_nxt(any_nxt)
  );

  hit_latch #(.N_COL(N_COL), .N_SUB(N_SUB)) u_lat (
    .clk(clk), .rst_n(rst_n),
    .up_d(up_hit), .lo_d(lo_hit), .coinc_d(coinc_nxt), .any_d(any_nxt),
    .up_q(up_q), .lo_q(lo_q), .coinc_q(coinc), .any_q(coinc_any)
  );

  assign frame = {coinc, lo_q, up_q, HDR_WORD};

  frame_serializer #(.FRAME_W(FRAME_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .frame(frame), .req(rd_req),
    .load_evt(load_evt), .busy(busy), .ser_data(ser_data)
  );

  assign ser_valid = busy;
endmodule

// File: rtl/strip_coinc_trigger_chk.sv
module strip_coinc_trigger_chk #(
  parameter int N_COL = 64,
  parameter int N_SUB = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_COL-1:0]       up_hit,
  input logic [N_COL*N_SUB-1:0] lo_hit,
  input logic                   rd_req,
  input logic [N_COL-1:0]       coinc,
  input logic                   coinc_any,
  input logic                   ser_valid,
  input logic                   ser_data,
  input logic                   busy,
  input logic                   load_evt
);
  localparam int FRAME_W = strip_coinc_pkg::frame_bits(N_COL, N_SUB);

  function automatic logic [N_COL-1:0] expect_flags(input logic [N_COL-1:0] u,
                                                    input logic [N_COL*N_SUB-1:0] l);
    logic [N_COL-1:0] r;
    for (int c = 0; c < N_COL; c++) begin
      r[c] = 1'b0;
      for (int s = 0; s < N_SUB; s++) r[c] = r[c] | (u[c] & l[c*N_SUB+s]);
    end
    return r;
  endfunction

  logic        past_ok;
  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      run_len <= '0;
    end else begin
      past_ok <= 1'b1;
      run_len <= busy ? run_len + 1 : 32'd0;
    end
  end

  a_r1_coinc_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> coinc == $past(expect_flags(up_hit, lo_hit)));

  a_r3_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
    coinc_any == (coinc != '0));

  a_r5_header_first: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> busy && ser_data);

  a_r6_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == FRAME_W);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> !ser_data);

  a_r4_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(busy) |-> $past(rd_req));
endmodule

bind strip_coinc_trigger strip_coinc_trigger_chk #(.N_COL(N_COL), .N_SUB(N_SUB)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_hit(up_hit), .lo_hit(lo_hit), .rd_req(rd_req),
  .coinc(coinc), .coinc_any(coinc_any), .ser_valid(ser_valid), .ser_data(ser_data),
  .busy(busy), .load_evt(load_evt)
);

// File: tb/strip_coinc_trigger_tb_top.sv
module strip_coinc_trigger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 64;
  localparam int NS = 5;
  localparam int NL = NC * NS;
  localparam int FW = 8 + NC + NL + NC;
  localparam logic [7:0] HDR = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] up_hit = '0;
  logic [NL-1:0] lo_hit = '0;
  logic          rd_req = 1'b0;
  logic [NC-1:0] coinc;
  logic          coinc_any, ser_valid, ser_data, busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  strip_coinc_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .up_hit(up_hit), .lo_hit(lo_hit), .rd_req(rd_req),
    .coinc(coinc), .coinc_any(coinc_any), .ser_valid(ser_valid),
    .ser_data(ser_data), .busy(busy)
  );

  // Column c counts as coincident when its upper bit is set and the
  // number of lit short strips in its group is non-zero.
  function automatic logic [NC-1:0] ref_coinc(input logic [NC-1:0] u, input logic [NL-1:0] l);
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++) begin
      int cnt = 0;
      for (int s = 0; s < NS; s++) cnt += int'(l[c*NS+s]);
      r[c] = u[c] && (cnt > 0);
    end
    return r;
  endfunction

  function automatic logic ref_bit(input int k, input logic [NC-1:0] u, input logic [NL-1:0] l);
    logic [NC-1:0] cf = ref_coinc(u, l);
    if (k < 8) return HDR[k];
    if (k < 8 + NC) return u[k-8];
    if (k < 8 + NC + NL) return l[k-8-NC];
    return cf[k-8-NC-NL];
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic rand_inputs(output logic [NC-1:0] u, output logic [NL-1:0] l);
    for (int i = 0; i < NC; i += 32) begin seed = xs(seed); u[i +: 32] = seed; end
    for (int i = 0; i < NL; i += 32) begin
      seed = xs(seed);
      l[i +: 32] = seed & xs(seed ^ 32'h55aa);  // sparser lower layer
    end
  endtask

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_check(input logic [NC-1:0] u, input logic [NL-1:0] l, input string req);
    logic [NC-1:0] e;
    up_hit = u; lo_hit = l;
    step();
    e = ref_coinc(u, l);
    check(req, 512'(coinc), 512'(e));
    check("R3 any", 512'(coinc_any), 512'(e != '0));
  endtask

  task automatic readout(input logic [NC-1:0] u, input logic [NL-1:0] l, input int poke_at);
    logic [NC-1:0] nu;
    logic [NL-1:0] nl;
    int bad = 0;
    int vbad = 0;
    int lbad = 0;
    up_hit = u; lo_hit = l;
    step();
    rd_req = 1'b1;            // R4: snapshot of the values latched now
    rand_inputs(nu, nl);
    up_hit = nu; lo_hit = nl;  // inputs change on the capture edge
    step();
    rd_req = 1'b0;
    for (int k = 0; k < FW; k++) begin
      if (ser_valid !== 1'b1) vbad++;
      if (ser_data !== ref_bit(k, u, l)) begin
        bad++;
        if (bad == 1)
          $display("FAIL R5 frame bit %0d actual=%0b expected=%0b", k, ser_data, ref_bit(k, u, l));
      end
      if (coinc !== ref_coinc(up_hit, lo_hit)) lbad++;
      rand_inputs(nu, nl);
      up_hit = nu; lo_hit = nl;
      rd_req = (k == poke_at);   // R7: request while busy
      step();
    end
    rd_req = 1'b0;
    checks++; if (bad != 0) errors++;           // R5 frame content (first bad bit printed above)
    check("R6 valid during frame", 512'(vbad), 512'(0));
    check("R8 live coinc during frame", 512'(lbad), 512'(0));
    check("R6 busy low after 456 cycles", 512'(busy), 512'(0));
    check("R7 no restart", 512'(ser_valid), 512'(0));
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NC-1:0] u;
    logic [NL-1:0] l;
    @(negedge clk);
    up_hit = '1; lo_hit = '1; rd_req = 1'b1;
    repeat (3) step();
    check("R9 coinc in reset", 512'(coinc), 512'(0));
    check("R9 flags in reset", 512'({coinc_any, busy, ser_valid, ser_data}), 512'(0));
    rd_req = 1'b0; up_hit = '0; lo_hit = '0;
    rst_n = 1'b1;
    step();
    check("R9 after release", 512'({coinc, coinc_any, busy, ser_valid, ser_data}), 512'(0));

    // R2: every short-strip position of every column alone
    for (int g = 0; g < NC; g++)
      for (int s = 0; s < NS; s++) begin
        l = '0; l[g*NS+s] = 1'b1;
        apply_check('1, l, "R2 position sweep");
      end
    // R1: upper strip required, and full group with one upper strip
    for (int g = 0; g < NC; g++) begin
      u = '0; u[g] = 1'b1;
      apply_check(u, '1, "R1 single upper");
      u = '1; l = '1; l[g*NS +: NS] = '0;
      apply_check(u, l, "R1 empty group");
    end
    apply_check('0, '1, "R1 no upper");
    apply_check('1, '0, "R1 no lower");
    for (int n = 0; n < 60; n++) begin
      rand_inputs(u, l);
      apply_check(u, l, "R1 random");
    end

    rand_inputs(u, l);
    readout(u, l, 100);
    rand_inputs(u, l);
    readout(u, l, FW - 1);     // request in the final busy cycle
    readout('1, '1, 0);
    readout('0, '0, 455);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule